// File: doc/BRIEF.md
# I2C Target Address Matcher

This block is the address-recognition front end of an I2C target. A bit-level receiver in front of it reports start and stop conditions and hands over each complete byte. The block takes the first byte after every start or repeated start (and, for a 10-bit address, the second byte) and compares it with four programmable ID registers. For each address byte it issues a one-cycle acknowledge request. When the device is fully addressed it also pulses a match strobe and reports which ID matched and the direction of the transfer.

In 7-bit mode the four IDs are independent 7-bit addresses. The low bit of each ID register sits at the direction-bit position and takes no part in the comparison. In 10-bit mode, ID0 holds the header byte of one 10-bit address and ID1 holds its low byte, while ID2 and ID3 keep working as 7-bit addresses. A read after a repeated start needs only the header byte, provided the previous 10-bit write address in the same transfer matched. The ID registers can be written only while no transfer is active.

Top module: `tgt_addr_match`

## Requirements
- R1: After reset, ack_o, match_o, match_idx_o and rd_o are 0, all ID registers are 0x00, and no transfer is active.
- R2: A write through id_we_i updates ID register id_sel_i only while no transfer is active. A transfer is active from a start until a stop. Writes while a transfer is active are dropped.
- R3: In 7-bit mode (ten_bit_i=0), the first byte after a start matches ID k when byte[7:1] equals ID k bits [7:1]; the ID's bit 0 is ignored. On a match, ack_o and match_o pulse high in the cycle after byte_valid_i. In that same cycle match_idx_o becomes k and rd_o becomes byte bit 0. Both then hold until the next match.
- R4: A first byte that matches no ID gives no ack_o and no match_o.
- R5: When several IDs match, match_idx_o reports the lowest-numbered one.
- R6: A repeated start (start_i without a stop in between) restarts address recognition, so the next byte is evaluated as a new first byte.
- R7: In 10-bit mode, a first byte with byte[7:3]=11110, byte[0]=0 and byte[7:1] equal to ID0[7:1] is acknowledged, without match_o. This holds only if ID0[7:3]=11110. The next byte must equal all eight bits of ID1; it is then acknowledged with match_o, match_idx_o=0 and rd_o=0.
- R8: In 10-bit mode, a second byte that differs from ID1 gives no ack_o and no match_o.
- R9: In 10-bit mode, ID2 and ID3 match as 7-bit addresses under the R3 rule, and ID1 is never matched as a 7-bit address.
- R10: In 10-bit mode, after a repeated start, a header byte with byte[0]=1 that matches ID0 is acknowledged with match_o, match_idx_o=0 and rd_o=1. This holds only if a full 10-bit write address matched earlier in the same transfer. After a stop or a reset this memory is cleared.
- R11: Bytes that are not the address phase produce no ack_o. This covers bytes received with no transfer active and bytes after the address phase has ended, whether it matched or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or repeated start detected (one-cycle pulse) |
| stop_i | input | 1 | Stop detected (one-cycle pulse) |
| byte_valid_i | input | 1 | A received byte is present on byte_i |
| byte_i | input | 8 | Received byte, MSB first on the bus |
| ten_bit_i | input | 1 | 1 selects 10-bit mode for ID0/ID1 |
| id_we_i | input | 1 | ID register write strobe |
| id_sel_i | input | 2 | ID register to write |
| id_wdata_i | input | 8 | ID register write data |
| ack_o | output | 1 | Request to drive ACK for the last byte (one-cycle pulse) |
| match_o | output | 1 | Device fully addressed (one-cycle pulse) |
| match_idx_o | output | 2 | Index of the matching ID |
| rd_o | output | 1 | Direction of the addressed transfer, 1 = read |

## Verification
The bound checker covers the rules that can be checked on every cycle. A match is always acknowledged and never repeats in the next cycle. Any acknowledge follows a byte that did not arrive together with a start. The ID registers do not move while a transfer is active. Every reported 7-bit match agrees with the stored ID and the received direction bit. A 10-bit write match implies the second byte equalled ID1 and ID0 carried the header, and ID1 is never reported in 10-bit mode. The bench scenarios are needed for the sequences the checker cannot see alone:
- a mismatch leaves the rest of the transfer silent;
- lowest-index priority;
- a repeated start re-arms recognition;
- a header-only read is refused after a stop;
- a write dropped mid-transfer is seen to have no effect.

// File: rtl/tam_pkg.sv
package tam_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADR1,
    ST_ADR2,
    ST_DATA,
    ST_SKIP
  } tam_state_e;

  localparam logic [4:0] TEN_HDR = 5'b11110;
endpackage

// File: rtl/tam_id_bank.sv
module tam_id_bank #(
  parameter int NUM_ID = 4,
  parameter int ID_W   = 8,
  localparam int IDX_W = (NUM_ID > 1) ? $clog2(NUM_ID) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         lock_i,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             sel_i,
  input  logic [ID_W-1:0]              wdata_i,
  output logic [NUM_ID-1:0][ID_W-1:0]  id_o
);
  for (genvar k = 0; k < NUM_ID; k++) begin : g_id
    logic wr_k;
    assign wr_k = we_i && !lock_i && (sel_i == IDX_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   id_o[k] <= '0;
      else if (wr_k) id_o[k] <= wdata_i;
    end
  end
endmodule

// File: rtl/tam_cmp.sv
module tam_cmp
  import tam_pkg::*;
#(
  parameter int NUM_ID = 4
) (
  input  logic [7:0]              byte_i,
  input  logic [NUM_ID-1:0][7:0]  id_i,
  input  logic                    ten_bit_i,
  output logic [NUM_ID-1:0]       hit7_o,
  output logic                    hdr_hit_o,
  output logic                    low_hit_o
);
  // IDs 0/1 form the 10-bit pair in ten-bit mode and drop out of 7-bit matching
  for (genvar k = 0; k < NUM_ID; k++) begin : g_cmp
    logic eq7;
    assign eq7 = (byte_i[7:1] == id_i[k][7:1]);
    if (k < 2) begin : g_pair
      assign hit7_o[k] = eq7 && !ten_bit_i;
    end else begin : g_plain
      assign hit7_o[k] = eq7;
    end
  end

  assign hdr_hit_o = (byte_i[7:3] == TEN_HDR) && (id_i[0][7:3] == TEN_HDR)
                   && (byte_i[2:1] == id_i[0][2:1]);
  assign low_hit_o = (byte_i == id_i[1]);
endmodule

// File: rtl/tam_prio.sv
module tam_prio #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IDX_W'(k);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/tgt_addr_match.sv
module tgt_addr_match
  import tam_pkg::*;
#(
  parameter int NUM_ID = 4,
  localparam int IDX_W = (NUM_ID > 1) ? $clog2(NUM_ID) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             ten_bit_i,
  input  logic             id_we_i,
  input  logic [IDX_W-1:0] id_sel_i,
  input  logic [7:0]       id_wdata_i,
  output logic             ack_o,
  output logic             match_o,
  output logic [IDX_W-1:0] match_idx_o,
  output logic             rd_o
);
  tam_state_e              st_q, st_d;
  logic                    active_q;
  logic                    ten_ok_q, ten_ok_d;
  logic                    ack_d, match_d, rd_d;
  logic [IDX_W-1:0]        idx_d;
  logic [NUM_ID-1:0][7:0]  id_q;
  logic [NUM_ID-1:0]       hit7;
  logic                    hdr_hit, low_hit, any7;
  logic [IDX_W-1:0]        idx7;

  assign active_q = (st_q != ST_IDLE);

  tam_id_bank #(.NUM_ID(NUM_ID), .ID_W(8)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lock_i  (active_q),
    .we_i    (id_we_i),
    .sel_i   (id_sel_i),
    .wdata_i (id_wdata_i),
    .id_o    (id_q)
  );

  tam_cmp #(.NUM_ID(NUM_ID)) u_cmp (
    .byte_i    (byte_i),
    .id_i      (id_q),
    .ten_bit_i (ten_bit_i),
    .hit7_o    (hit7),
    .hdr_hit_o (hdr_hit),
    .low_hit_o (low_hit)
  );

  tam_prio #(.N(NUM_ID)) u_prio (
    .req_i (hit7),
    .any_o (any7),
    .idx_o (idx7)
  );

  always_comb begin
    st_d     = st_q;
    ten_ok_d = ten_ok_q;
    ack_d    = 1'b0;
    match_d  = 1'b0;
    idx_d    = match_idx_o;
    rd_d     = rd_o;
    if (start_i) begin
      st_d = ST_ADR1;
    end else if (stop_i) begin
      st_d     = ST_IDLE;
      ten_ok_d = 1'b0;
    end else if (byte_valid_i) begin
      unique case (st_q)
        ST_ADR1: begin
          if (ten_bit_i && hdr_hit && !byte_i[0]) begin
            ack_d    = 1'b1;
            ten_ok_d = 1'b0;
            st_d     = ST_ADR2;
          end else if (ten_bit_i && hdr_hit && byte_i[0] && ten_ok_q) begin
            // header-only read after repeated start
            ack_d   = 1'b1;
            match_d = 1'b1;
            idx_d   = '0;
            rd_d    = 1'b1;
            st_d    = ST_DATA;
          end else if (any7) begin
            ack_d    = 1'b1;
            match_d  = 1'b1;
            idx_d    = idx7;
            rd_d     = byte_i[0];
            ten_ok_d = 1'b0;
            st_d     = ST_DATA;
          end else begin
            ten_ok_d = 1'b0;
            st_d     = ST_SKIP;
          end
        end
        ST_ADR2: begin
          if (low_hit) begin
            ack_d    = 1'b1;
            match_d  = 1'b1;
            idx_d    = '0;
            rd_d     = 1'b0;
            ten_ok_d = 1'b1;
            st_d     = ST_DATA;
          end else begin
            st_d = ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ten_ok_q    <= 1'b0;
      ack_o       <= 1'b0;
      match_o     <= 1'b0;
      match_idx_o <= '0;
      rd_o        <= 1'b0;
    end else begin
      st_q        <= st_d;
      ten_ok_q    <= ten_ok_d;
      ack_o       <= ack_d;
      match_o     <= match_d;
      match_idx_o <= idx_d;
      rd_o        <= rd_d;
    end
  end
endmodule

// File: rtl/tam_checker.sv
module tam_checker #(
  parameter int NUM_ID = 4,
  localparam int IDX_W = (NUM_ID > 1) ? $clog2(NUM_ID) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic                   byte_valid_i,
  input logic [7:0]             byte_i,
  input logic                   ten_bit_i,
  input logic                   active_q,
  input logic [NUM_ID-1:0][7:0] id_q,
  input logic                   ack_o,
  input logic                   match_o,
  input logic [IDX_W-1:0]       match_idx_o,
  input logic                   rd_o
);
  p_match_acked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> ack_o);

  p_match_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);

  p_ack_after_byte_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ($past(byte_valid_i) && !$past(start_i)));

  p_ids_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |=> $stable(id_q));

  p_seven_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !$past(ten_bit_i)) |->
      ($past(byte_i[7:1]) == id_q[match_idx_o][7:1] && rd_o == $past(byte_i[0])));

  p_ten_low_byte_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && $past(ten_bit_i) && match_idx_o == '0 && !rd_o) |->
      ($past(byte_i) == id_q[1] && id_q[0][7:3] == 5'b11110));

  p_ten_no_id1_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && $past(ten_bit_i)) |-> (match_idx_o != IDX_W'(1)));
endmodule

bind tgt_addr_match tam_checker #(.NUM_ID(NUM_ID)) u_tam_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .byte_valid_i (byte_valid_i),
  .byte_i       (byte_i),
  .ten_bit_i    (ten_bit_i),
  .active_q     (active_q),
  .id_q         (id_q),
  .ack_o        (ack_o),
  .match_o      (match_o),
  .match_idx_o  (match_idx_o),
  .rd_o         (rd_o)
);

// File: tb/tgt_addr_match_bench.sv
module tgt_addr_match_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stop = 1'b0, bv = 1'b0, ten = 1'b0;
  logic [7:0] bdat = '0;
  logic       we = 1'b0;
  logic [1:0] sel = '0;
  logic [7:0] wdat = '0;
  logic       ack, mat, rd;
  logic [1:0] idx;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  tgt_addr_match u_tgt_addr_match (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .byte_valid_i(bv), .byte_i(bdat), .ten_bit_i(ten),
    .id_we_i(we), .id_sel_i(sel), .id_wdata_i(wdat),
    .ack_o(ack), .match_o(mat), .match_idx_o(idx), .rd_o(rd)
  );

  task automatic chk(string req, logic e_ack, logic e_mat, logic [1:0] e_idx, logic e_rd);
    n_chk++;
    if (ack !== e_ack || mat !== e_mat || (e_mat && (idx !== e_idx || rd !== e_rd))) begin
      n_bad++;
      $display("FAIL %s: ack/match/idx/rd = %b/%b/%0d/%b, expected %b/%b/%0d/%b",
               req, ack, mat, idx, rd, e_ack, e_mat, e_idx, e_rd);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  // outputs update at the edge after the byte; sampled on the next falling edge
  task automatic send(logic [7:0] b);
    @(negedge clk) begin bv = 1'b1; bdat = b; end
    @(negedge clk) bv = 1'b0;
  endtask

  task automatic wr_id(logic [1:0] s, logic [7:0] d);
    @(negedge clk) begin we = 1'b1; sel = s; wdat = d; end
    @(negedge clk) we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset", 1'b0, 1'b0, 2'd0, 1'b0);
    if (idx !== 2'd0 || rd !== 1'b0) begin
      n_bad++; $display("FAIL R1 idx/rd = %0d/%b, expected 0/0", idx, rd);
    end
    n_chk++;
    send(8'h00);                      // IDs all 0x00 but no transfer active
    chk("R11 byte while idle", 1'b0, 1'b0, 2'd0, 1'b0);
    pulse_start(); send(8'h01);       // reset IDs are 0x00
    chk("R1 reset ID value", 1'b1, 1'b1, 2'd0, 1'b1);
    pulse_stop();
  endtask

  task automatic t_seven();
    wr_id(2'd0, 8'h50); wr_id(2'd1, 8'h24); wr_id(2'd2, 8'h37); wr_id(2'd3, 8'h51);
    pulse_start(); send(8'h24);
    chk("R3 write to ID1", 1'b1, 1'b1, 2'd1, 1'b0);
    send(8'h24);
    chk("R11 byte after address phase", 1'b0, 1'b0, 2'd0, 1'b0);
    pulse_start(); send(8'h36);
    chk("R3 ID LSB ignored", 1'b1, 1'b1, 2'd2, 1'b0);
    pulse_start(); send(8'h37);
    chk("R3 read to ID2", 1'b1, 1'b1, 2'd2, 1'b1);
    pulse_start(); send(8'h51);
    chk("R5 lowest ID wins", 1'b1, 1'b1, 2'd0, 1'b1);
    pulse_stop();
  endtask

  task automatic t_miss_restart();
    pulse_start(); send(8'h7E);
    chk("R4 no match", 1'b0, 1'b0, 2'd0, 1'b0);
    send(8'h24);
    chk("R11 byte after miss", 1'b0, 1'b0, 2'd0, 1'b0);
    pulse_start(); send(8'h24);
    chk("R6 repeated start", 1'b1, 1'b1, 2'd1, 1'b0);
    pulse_stop();
  endtask

  task automatic t_lock();
    pulse_start(); send(8'h24);
    wr_id(2'd1, 8'h66);               // dropped: transfer active
    pulse_start(); send(8'h24);
    chk("R2 write during transfer dropped", 1'b1, 1'b1, 2'd1, 1'b0);
    pulse_stop();
    wr_id(2'd1, 8'h66);
    pulse_start(); send(8'h66);
    chk("R2 write while idle", 1'b1, 1'b1, 2'd1, 1'b0);
    pulse_stop();
  endtask

  task automatic t_ten();
    wr_id(2'd0, 8'hF2); wr_id(2'd1, 8'h5A);
    @(negedge clk) ten = 1'b1;
    pulse_start(); send(8'hF2);
    chk("R7 header acked", 1'b1, 1'b0, 2'd0, 1'b0);
    send(8'h5A);
    chk("R7 low byte match", 1'b1, 1'b1, 2'd0, 1'b0);
    pulse_start(); send(8'hF3);
    chk("R10 header-only read", 1'b1, 1'b1, 2'd0, 1'b1);
    pulse_stop();
    pulse_start(); send(8'hF3);
    chk("R10 read refused after stop", 1'b0, 1'b0, 2'd0, 1'b0);
    pulse_start(); send(8'hF2);
    chk("R7 header acked again", 1'b1, 1'b0, 2'd0, 1'b0);
    send(8'h5B);
    chk("R8 low byte mismatch", 1'b0, 1'b0, 2'd0, 1'b0);
    pulse_start(); send(8'h36);
    chk("R9 ID2 stays 7-bit", 1'b1, 1'b1, 2'd2, 1'b0);
    pulse_start(); send(8'h5A);
    chk("R9 ID1 not 7-bit", 1'b0, 1'b0, 2'd0, 1'b0);
    pulse_stop();
    wr_id(2'd0, 8'h52);               // no 11110 header in ID0
    pulse_start(); send(8'h52);
    chk("R7 ID0 needs header", 1'b0, 1'b0, 2'd0, 1'b0);
    pulse_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seven();
    t_miss_restart();
    t_lock();
    t_ten();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule